// File: doc/BRIEF.md
# I2C Command Register Window

This block sits between a host register bus and an I2C transaction engine that serves a hot-plug controller. The host describes one transaction at a time. It writes an operation-setup word, loads a message buffer with the data byte and then sets a start bit in a control register. The block decodes the setup word into a single request on a plain downstream request/response port. When the response comes back, it puts read data into the buffer, drops the start bit and records the outcome in a status register.

Every register can be written three ways: plainly, through a window that ORs the store into the current value, or through a window that ANDs it in. This lets the host set or clear single bits in one store. The register contents are kept in big-endian order inside the block, and the host side sees every 32-bit word with its bytes reversed, on both stores and loads. A failed transaction is recognised by any nonzero bit under the status failure mask.

Top module: `i2c_cmd_window`

## Requirements
- R1: After reset the buffer, setup, control and status registers all read 0 and req_valid is low.
- R2: A host word H is held internally as H with its four bytes reversed, and loads return the internal value reversed again, so a plain store at offset 0x008 (buffer) or 0x010 (setup) reads back as H while the decoded fields come from the reversed value.
- R3: A store at a register offset plus 0x2000 ORs the data into the register, and a store at the offset plus 0x1000 ANDs it in; offsets 0x020 (control) and 0x070 (status) complete the map, and status ignores stores.
- R4: A store that makes internal control bit 1 equal to 1 while idle, with a valid setup opcode, raises req_valid for exactly one cycle starting on the next cycle, and control bit 1 reads 1 until completion.
- R5: Internal setup bits 31:16 equal to 0x0001 request an addressed read and 0x4001 an addressed write; req_dev takes setup bits 14:8, req_index takes bits 7:0 and req_direct is 0.
- R6: Setup bits 31:16 equal to 0x1001 request a direct read and 0x6001 a direct write; req_index takes setup bits 15:8, req_dev is 0 and req_direct is 1.
- R7: A write request carries the internal buffer bits 7:0 on req_data; an acknowledged read response replaces internal buffer bits 7:0 with rsp_data and keeps bits 31:8.
- R8: rsp_valid during a transaction clears control bit 1 and status bit 1 (busy) on the next cycle; status bit 1 reads 1 while the transaction is outstanding, and a transaction succeeded when internal status AND 0x00000A76 is 0.
- R9: A response with rsp_ack low sets status bit 2 and leaves the buffer unchanged; the next start clears it.
- R10: A start with any other setup opcode issues no request, leaves control bit 1 at 0 and sets status bit 9, which the next start clears.
- R11: Stores to setup, buffer or control while control bit 1 is set are ignored, and rsp_valid while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host store strobe |
| bus_addr | input | ADDR_W (14) | Host byte address: bits 11:0 register offset, bits 13:12 store kind |
| bus_wdata | input | DW (32) | Host store data (host byte order) |
| bus_rdata | output | DW (32) | Host load data for bus_addr (host byte order) |
| req_valid | output | 1 | One-cycle transaction request |
| req_write | output | 1 | 1 for a write transaction |
| req_direct | output | 1 | 1 for direct mode, 0 for addressed |
| req_dev | output | 7 | 7-bit target address (0 in direct mode) |
| req_index | output | 8 | Register index in the target |
| req_data | output | 8 | Data byte for a write transaction |
| rsp_valid | input | 1 | Transaction finished |
| rsp_ack | input | 1 | Target acknowledged |
| rsp_data | input | 8 | Byte returned by a read transaction |

## Verification
The case of interest is a host store landing in the same cycle as the response that completes a transaction. A store to the buffer in that cycle must lose to the returned byte, because the start bit is still set at that edge. The bench switches its engine model to manual mode and drives rsp_valid together with a buffer store on the same falling edge. It then requires the buffer to hold the old upper bytes with the returned low byte, and control bit 1 to be clear. A randomised run of mixed addressed, direct, acknowledged, refused and malformed transactions checks the decoded request and the final register state against values the bench computes.

// File: rtl/i2c_win_pkg.sv
package i2c_win_pkg;
   typedef enum logic [1:0] {
      ST_PLAIN = 2'd0,
      ST_AND   = 2'd1,
      ST_OR    = 2'd2,
      ST_NONE  = 2'd3
   } store_e;

   localparam logic [11:0] OFS_BUF   = 12'h008;
   localparam logic [11:0] OFS_SETUP = 12'h010;
   localparam logic [11:0] OFS_CTRL  = 12'h020;
   localparam logic [11:0] OFS_STAT  = 12'h070;

   localparam logic [15:0] OP_ADDR_RD = 16'h0001;
   localparam logic [15:0] OP_ADDR_WR = 16'h4001;
   localparam logic [15:0] OP_DIR_RD  = 16'h1001;
   localparam logic [15:0] OP_DIR_WR  = 16'h6001;

   localparam int START_BIT    = 1;
   localparam int ST_BUSY_BIT  = 1;
   localparam int ST_NACK_BIT  = 2;
   localparam int ST_BADOP_BIT = 9;

   typedef struct packed {
      logic       ok;
      logic       wr;
      logic       direct;
      logic [6:0] dev;
      logic [7:0] index;
   } txn_req_t;
endpackage

// File: rtl/win_lane_swap.sv
module win_lane_swap #(
   parameter int DW   = 32,
   parameter bit SWAP = 1'b1
) (
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   localparam int NB = DW / 8;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("win_lane_swap: DW must be a whole number of bytes");
   end

   if (SWAP) begin : g_swap
      for (genvar b = 0; b < NB; b++) begin : g_lane
         assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
      end
   end else begin : g_pass
      assign dout = din;
   end
endmodule

// File: rtl/win_store_alu.sv
module win_store_alu
   import i2c_win_pkg::*;
#(
   parameter int DW = 32
) (
   input  store_e        kind,
   input  logic [DW-1:0] cur,
   input  logic [DW-1:0] wdat,
   output logic [DW-1:0] nxt
);
   always_comb begin
      unique case (kind)
         ST_AND:  nxt = cur & wdat;
         ST_OR:   nxt = cur | wdat;
         ST_NONE: nxt = cur;
         default: nxt = wdat;
      endcase
   end
endmodule

// File: rtl/win_setup_decode.sv
module win_setup_decode
   import i2c_win_pkg::*;
(
   input  logic [31:0] setup,
   output txn_req_t    dec
);
   logic [15:0] op;
   assign op = setup[31:16];

   always_comb begin
      dec.ok     = (op == OP_ADDR_RD) || (op == OP_ADDR_WR) ||
                   (op == OP_DIR_RD)  || (op == OP_DIR_WR);
      dec.wr     = (op == OP_ADDR_WR) || (op == OP_DIR_WR);
      dec.direct = (op == OP_DIR_RD)  || (op == OP_DIR_WR);
      dec.dev    = dec.direct ? 7'd0 : setup[14:8];
      dec.index  = dec.direct ? setup[15:8] : setup[7:0];
   end
endmodule

// File: rtl/win_txn_ctrl.sv
module win_txn_ctrl
   import i2c_win_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  txn_req_t   dec,
   input  logic [7:0] buf_lo,
   input  logic       rsp_valid,
   input  logic       rsp_ack,
   output logic       busy,
   output logic       err_nack,
   output logic       err_badop,
   output logic       capture,
   output logic       req_valid,
   output logic       req_write,
   output logic       req_direct,
   output logic [6:0] req_dev,
   output logic [7:0] req_index,
   output logic [7:0] req_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         err_nack   <= 1'b0;
         err_badop  <= 1'b0;
         req_valid  <= 1'b0;
         req_write  <= 1'b0;
         req_direct <= 1'b0;
         req_dev    <= '0;
         req_index  <= '0;
         req_data   <= '0;
      end else begin
         req_valid <= 1'b0;
         if (launch) begin
            err_nack  <= 1'b0;
            err_badop <= !dec.ok;
            if (dec.ok) begin
               busy       <= 1'b1;
               req_valid  <= 1'b1;
               req_write  <= dec.wr;
               req_direct <= dec.direct;
               req_dev    <= dec.dev;
               req_index  <= dec.index;
               req_data   <= buf_lo;
            end
         end else if (busy && rsp_valid) begin
            busy     <= 1'b0;
            err_nack <= !rsp_ack;
         end
      end
   end

   assign capture = busy && rsp_valid && rsp_ack && !req_write;

   // R4
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);
   // R8
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsp_valid) |=> !busy);
   // R9
   nack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsp_valid && !rsp_ack) |=> err_nack);
   // R10
   badop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !dec.ok) |=> (err_badop && !busy && !req_valid));
endmodule

// File: rtl/i2c_cmd_window.sv
module i2c_cmd_window
   import i2c_win_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int DW        = 32,
   parameter bit BYTE_SWAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              req_valid,
   output logic              req_write,
   output logic              req_direct,
   output logic [6:0]        req_dev,
   output logic [7:0]        req_index,
   output logic [7:0]        req_data,
   input  logic              rsp_valid,
   input  logic              rsp_ack,
   input  logic [7:0]        rsp_data
);
   localparam int OFS_W = 12;

   if (ADDR_W < OFS_W + 2) begin : g_bad_aw
      $error("i2c_cmd_window: ADDR_W must cover the store-kind bits");
   end
   if (DW != 32) begin : g_bad_dw
      $error("i2c_cmd_window: setup decode needs DW of 32");
   end

   logic [OFS_W-1:0] ofs;
   store_e           kind;
   logic             sel_buf, sel_setup, sel_ctrl, sel_stat;
   logic [DW-1:0]    wint, cur, nxt, rint;
   logic [DW-1:0]    buf_q, setup_q, ctrl_int, stat_int;
   logic             busy, err_nack, err_badop, capture, launch, st_ok;
   txn_req_t         dec;

   assign ofs       = bus_addr[OFS_W-1:0];
   assign kind      = store_e'(bus_addr[OFS_W+1:OFS_W]);
   assign sel_buf   = (ofs == OFS_BUF);
   assign sel_setup = (ofs == OFS_SETUP);
   assign sel_ctrl  = (ofs == OFS_CTRL);
   assign sel_stat  = (ofs == OFS_STAT);
   assign st_ok     = bus_wr && (kind != ST_NONE) && !busy;

   win_lane_swap #(.DW(DW), .SWAP(BYTE_SWAP)) u_swap_in  (.din(bus_wdata), .dout(wint));
   win_lane_swap #(.DW(DW), .SWAP(BYTE_SWAP)) u_swap_out (.din(rint),      .dout(bus_rdata));

   always_comb begin
      if (sel_buf)        cur = buf_q;
      else if (sel_setup) cur = setup_q;
      else                cur = ctrl_int;
   end

   win_store_alu #(.DW(DW)) u_alu (.kind(kind), .cur(cur), .wdat(wint), .nxt(nxt));

   win_setup_decode u_dec (.setup(setup_q), .dec(dec));

   assign launch = st_ok && sel_ctrl && nxt[START_BIT];

   win_txn_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .launch(launch), .dec(dec), .buf_lo(buf_q[7:0]),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .busy(busy), .err_nack(err_nack),
      .err_badop(err_badop), .capture(capture), .req_valid(req_valid),
      .req_write(req_write), .req_direct(req_direct), .req_dev(req_dev),
      .req_index(req_index), .req_data(req_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q   <= '0;
         setup_q <= '0;
      end else begin
         if (capture)
            buf_q[7:0] <= rsp_data;
         else if (st_ok && sel_buf)
            buf_q <= nxt;
         if (st_ok && sel_setup)
            setup_q <= nxt;
      end
   end

   always_comb begin
      ctrl_int               = '0;
      ctrl_int[START_BIT]    = busy;
      stat_int               = '0;
      stat_int[ST_BUSY_BIT]  = busy;
      stat_int[ST_NACK_BIT]  = err_nack;
      stat_int[ST_BADOP_BIT] = err_badop;
   end

   always_comb begin
      if (sel_buf)        rint = buf_q;
      else if (sel_setup) rint = setup_q;
      else if (sel_ctrl)  rint = ctrl_int;
      else if (sel_stat)  rint = stat_int;
      else                rint = '0;
   end

   // R11
   buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rsp_valid) |=> $stable(buf_q));
   // R11
   setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(setup_q));
   // R7
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (buf_q[7:0] == $past(rsp_data) && buf_q[DW-1:8] == $past(buf_q[DW-1:8])));
endmodule

// File: tb/i2c_cmd_window_test.sv
module i2c_cmd_window_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [13:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req_valid, req_write, req_direct;
   logic [6:0]  req_dev;
   logic [7:0]  req_index, req_data;
   logic        rsp_valid = 1'b0;
   logic        rsp_ack = 1'b0;
   logic [7:0]  rsp_data = '0;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   i2c_cmd_window uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
      .req_write(req_write), .req_direct(req_direct), .req_dev(req_dev),
      .req_index(req_index), .req_data(req_data), .rsp_valid(rsp_valid),
      .rsp_ack(rsp_ack), .rsp_data(rsp_data)
   );

   localparam logic [13:0] A_BUF = 14'h008, A_SET = 14'h010, A_CTL = 14'h020, A_STA = 14'h070;
   localparam logic [13:0] A_AND = 14'h1000, A_OR = 14'h2000;

   function automatic logic [31:0] rev(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic logic [31:0] mk_setup(input int kind, input logic [6:0] dev, input logic [7:0] idx);
      case (kind)
         0: return {16'h0001, 1'b0, dev, idx};
         1: return {16'h4001, 1'b0, dev, idx};
         2: return {16'h1001, idx, 8'h00};
         3: return {16'h6001, idx, 8'h00};
         default: return {16'h2001, 1'b0, dev, idx};
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_raw(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_int(input logic [13:0] a, input logic [31:0] d);
      wr_raw(a, rev(d));
   endtask

   task automatic rd_raw(input logic [13:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd_int(input logic [13:0] a, output logic [31:0] d);
      logic [31:0] t;
      rd_raw(a, t);
      d = rev(t);
   endtask

   // engine model
   bit          auto_phy = 1;
   int          dly_q = 2;
   bit          ack_q = 1;
   logic [7:0]  rdat_q = '0;
   int          req_total = 0;
   logic        c_wr, c_dir;
   logic [6:0]  c_dev;
   logic [7:0]  c_idx, c_dat;

   always @(posedge clk) if (req_valid) req_total <= req_total + 1;

   initial begin
      forever begin
         @(negedge clk);
         if (auto_phy && req_valid) begin
            c_wr = req_write; c_dir = req_direct; c_dev = req_dev;
            c_idx = req_index; c_dat = req_data;
            repeat (dly_q) @(negedge clk);
            rsp_valid = 1'b1; rsp_ack = ack_q; rsp_data = rdat_q;
            @(negedge clk);
            rsp_valid = 1'b0;
         end
      end
   end

   task automatic wait_idle();
      logic [31:0] c;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         rd_int(A_CTL, c);
         if (c[1] == 1'b0) break;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, bufi, exp_buf;
      int n0;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_raw(A_BUF, v); chk("R1 buffer", v, 0);
      rd_raw(A_SET, v); chk("R1 setup", v, 0);
      rd_raw(A_CTL, v); chk("R1 control", v, 0);
      rd_raw(A_STA, v); chk("R1 status", v, 0);
      chk("R1 req_valid", {31'd0, req_valid}, 0);

      // R2 host readback and lane order
      wr_raw(A_BUF, 32'h11223344);
      rd_raw(A_BUF, v); chk("R2 buffer readback", v, 32'h11223344);
      // R3 OR and AND windows
      wr_raw(A_BUF | A_OR, 32'h000000F0);
      rd_raw(A_BUF, v); chk("R3 OR window", v, 32'h112233F4);
      wr_raw(A_BUF | A_AND, 32'hFFFF00FF);
      rd_raw(A_BUF, v); chk("R3 AND window", v, 32'h112200F4);
      wr_raw(A_STA, 32'hFFFFFFFF);
      rd_raw(A_STA, v); chk("R3 status ignores stores", v, 0);

      // R2 decoded fields come from the reversed word: internal 0x40012A5A
      wr_raw(A_SET, 32'h5A2A0140);
      rd_raw(A_SET, v); chk("R2 setup readback", v, 32'h5A2A0140);
      wr_int(A_BUF, 32'h000000C3);
      dly_q = 8; ack_q = 1;
      n0 = req_total;
      wr_int(A_CTL | A_OR, 32'h2);
      // R4 / R8 while outstanding
      rd_int(A_CTL, v); chk("R4 start held", v, 32'h2);
      rd_int(A_STA, v); chk("R8 busy status", v, 32'h2);
      // R11 stores ignored while busy
      wr_int(A_BUF, 32'hDEADBEEF);
      wr_int(A_SET, 32'h00010000);
      wr_int(A_CTL | A_AND, 32'h0);
      rd_int(A_BUF, v); chk("R11 buffer store ignored", v, 32'h000000C3);
      rd_int(A_SET, v); chk("R11 setup store ignored", v, 32'h40012A5A);
      rd_int(A_CTL, v); chk("R11 control store ignored", v, 32'h2);
      wait_idle();
      chk("R4 one request", req_total - n0, 1);
      chk("R5 addressed write fields", {c_wr, c_dir, c_dev, c_idx}, {1'b1, 1'b0, 7'h2A, 8'h5A});
      chk("R7 write data byte", {24'd0, c_dat}, 32'hC3);
      rd_int(A_STA, v); chk("R8 success status", v & 32'h0A76, 0);

      // R11 stray response when idle
      @(negedge clk);
      rsp_valid = 1'b1; rsp_ack = 1'b0; rsp_data = 8'h99;
      @(negedge clk);
      rsp_valid = 1'b0;
      rd_int(A_BUF, v); chk("R11 idle response buffer", v, 32'h000000C3);
      rd_int(A_STA, v); chk("R11 idle response status", v, 0);

      // same cycle: completion and buffer store
      auto_phy = 0;
      wr_int(A_SET, mk_setup(0, 7'h11, 8'h22));
      wr_int(A_BUF, 32'hAABBCC00);
      wr_int(A_CTL, 32'h2);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_ack = 1'b1; rsp_data = 8'h77;
      bus_wr = 1'b1; bus_addr = A_BUF; bus_wdata = rev(32'h12345678);
      @(negedge clk);
      rsp_valid = 1'b0; bus_wr = 1'b0;
      rd_int(A_BUF, v); chk("R7 read byte wins over store", v, 32'hAABBCC77);
      rd_int(A_CTL, v); chk("R8 start cleared", v, 0);
      auto_phy = 1;

      // random mix
      bufi = 32'hAABBCC77;
      for (int t = 0; t < 60; t++) begin
         int kind;
         logic [6:0] dev;
         logic [7:0] idx;
         kind = ($urandom_range(0, 9) == 0) ? 4 : int'($urandom_range(0, 3));
         dev = 7'($urandom); idx = 8'($urandom);
         bufi = $urandom;
         dly_q = $urandom_range(2, 6);
         ack_q = ($urandom_range(0, 3) != 0);
         rdat_q = 8'($urandom);
         wr_int(A_SET, mk_setup(kind, dev, idx));
         wr_int(A_BUF, bufi);
         n0 = req_total;
         wr_int(A_CTL | A_OR, 32'h2);
         if (kind == 4) begin
            rd_int(A_CTL, v); chk("R10 start not held", v, 0);
            @(negedge clk);
            chk("R10 no request", req_total - n0, 0);
            rd_int(A_STA, v); chk("R10 bad opcode status", v, 32'h200);
            rd_int(A_BUF, v); chk("R10 buffer kept", v, bufi);
         end else begin
            wait_idle();
            chk("R4 single request", req_total - n0, 1);
            chk("R4 request write bit", {31'd0, c_wr}, (kind == 1 || kind == 3));
            if (kind < 2)
               chk("R5 addressed fields", {c_dir, c_dev, c_idx}, {1'b0, dev, idx});
            else
               chk("R6 direct fields", {c_dir, c_dev, c_idx}, {1'b1, 7'd0, idx});
            if (c_wr) chk("R7 write data", {24'd0, c_dat}, {24'd0, bufi[7:0]});
            exp_buf = (!c_wr && ack_q) ? {bufi[31:8], rdat_q} : bufi;
            rd_int(A_BUF, v); chk("R7 R9 buffer after done", v, exp_buf);
            rd_int(A_STA, v); chk("R8 R9 status after done", v, ack_q ? 32'h0 : 32'h4);
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule